// File: doc/BRIEF.md
# Per-Phase Apparent Power Calculator

This block computes the apparent power of three phases. Each phase takes an RMS voltage and an RMS current sample, multiplies them, and cuts the product down to a 28-bit signed word. A signed fractional gain then scales the word, and the result saturates at the 28-bit limits. Any phase can be switched to a fixed nominal RMS voltage held in a configuration register. That phase then computes nominal voltage times its measured RMS current. No offset term is added at the product stage, because offsets are assumed to be removed in the RMS inputs.

One input beat carries the RMS pairs for all three phases under a valid/ready handshake. One output beat carries all three results under its own valid/ready handshake. A beat is transferred on a rising edge where valid and ready are both high. Once out_valid is high, it stays high and out_va stays unchanged until out_ready is seen high. in_valid must be held with unchanged data until in_ready is seen high. The two pipeline stages stall together when the output is not taken.

A plain write port loads the nominal voltage, the mode bits and the three gain words into shadow registers. An input beat takes a snapshot of the shadow registers on the edge where it is accepted, so a write never alters a sample already in flight.

Top module: `phase_va_calc`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is 0 and in_ready is 1. Nominal voltage, mode and all gains reset to 0.
- R2: A phase with its mode bit at 0 outputs floor(V×I / 2^21), where V and I are its 24-bit unsigned RMS voltage and current. This holds with gain 0.
- R3: Write address 1 is the mode word. Bit 11 selects nominal mode for phase A, bit 12 for phase B and bit 13 for phase C. A phase in nominal mode uses the nominal voltage (write address 0, bits 23:0, unsigned) in place of its measured voltage. The other phases are unaffected.
- R4: Write addresses 2, 3 and 4 hold the gain words of phases A, B and C. Each gain is bits 23:0, read as two's complement g. The output is p + floor(p×g / 2^23), where p is the R2/R3 product. 0xC00000 halves p and 0x400000 multiplies it by 1.5.
- R5: A gained result above 0x7FFFFFF is clamped to 0x7FFFFFF. A result below −2^27 is clamped to −2^27.
- R6: Write-data bits 31:24 of gain and nominal writes have no effect. Mode bits other than 13:11 have no effect. Writes to addresses 5 to 7 have no effect.
- R7: A beat accepted in cycle n appears with out_valid high in cycle n+2 when out_ready is high. out_valid is low in cycle n+1 if nothing else is in flight.
- R8: While out_valid is high and out_ready is low, out_va holds its value. in_ready falls once both stages are full. Beats leave in the order they were accepted.
- R9: A beat uses the register values in place before its accepting edge. A write in the same cycle as the acceptance, or in a later cycle, applies only to later beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_vrms | input | 72 | RMS voltages, phase k at bits [24k+23:24k] |
| in_irms | input | 72 | RMS currents, phase k at bits [24k+23:24k] |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address: 0 nominal, 1 mode, 2–4 gain A–C |
| cfg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken when high with out_valid |
| out_va | output | 84 | Apparent power, phase k at bits [28k+27:28k], signed |

## Verification
A beat driven with valid high in cycle n is sampled at the falling edge of cycle n+1, where out_valid must still be low. It is sampled again at the falling edge of cycle n+2, where all three results must be present. These counts come from the two registers on the path: the product register and the output register.

Register writes are mirrored in the bench with the R6 masking. Expected values are computed from the mirror as it stood before the accepting edge. This lets the same-cycle and in-flight write cases of R9 be checked against the older settings.

Under back-pressure, the outputs are read at each falling edge while out_ready is low. After release, each beat is read one cycle apart, in the order it was accepted.

// File: rtl/phase_va_pkg.sv
package phase_va_pkg;
  localparam int NUM_PH_D   = 3;
  localparam int RMS_W_D    = 24;
  localparam int VA_W_D     = 28;
  localparam int GAIN_W_D   = 24;
  localparam int CFG_AW_D   = 3;
  localparam int CFG_DW_D   = 32;
  localparam int MODE_LSB_D = 11;

  localparam int ADDR_NOM   = 0;
  localparam int ADDR_MODE  = 1;
  localparam int ADDR_GAIN0 = 2;
endpackage

// File: rtl/phase_va_cfg.sv
module phase_va_cfg #(
  parameter int NUM_PH   = 3,
  parameter int RMS_W    = 24,
  parameter int GAIN_W   = 24,
  parameter int CFG_AW   = 3,
  parameter int CFG_DW   = 32,
  parameter int MODE_LSB = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [CFG_DW-1:0]        cfg_wdata,
  output logic [RMS_W-1:0]         nom_v,
  output logic [NUM_PH-1:0]        nom_sel,
  output logic [NUM_PH*GAIN_W-1:0] gain_flat
);
  import phase_va_pkg::*;

  logic hit_nom, hit_mode;
  assign hit_nom  = cfg_we && (cfg_addr == CFG_AW'(ADDR_NOM));
  assign hit_mode = cfg_we && (cfg_addr == CFG_AW'(ADDR_MODE));

  always_ff @(posedge clk) begin
    if (!rst_n)       nom_v <= '0;
    else if (hit_nom) nom_v <= cfg_wdata[RMS_W-1:0];
  end

  for (genvar ph = 0; ph < NUM_PH; ph++) begin : g_ph
    logic hit_gain;
    assign hit_gain = cfg_we && (cfg_addr == CFG_AW'(ADDR_GAIN0 + ph));

    always_ff @(posedge clk) begin
      if (!rst_n)        gain_flat[ph*GAIN_W +: GAIN_W] <= '0;
      else if (hit_gain) gain_flat[ph*GAIN_W +: GAIN_W] <= cfg_wdata[GAIN_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        nom_sel[ph] <= 1'b0;
      else if (hit_mode) nom_sel[ph] <= cfg_wdata[MODE_LSB + ph];
    end
  end
endmodule

// File: rtl/phase_va_pipe_ctl.sv
module phase_va_pipe_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic out_ready,
  output logic st1_valid,
  output logic st2_valid,
  output logic ld1,
  output logic ld2
);
  logic adv1, adv2;

  assign adv2     = !st2_valid || out_ready;
  assign adv1     = !st1_valid || adv2;
  assign in_ready = adv1;
  assign ld1      = in_valid && adv1;
  assign ld2      = st1_valid && adv2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1_valid <= 1'b0;
      st2_valid <= 1'b0;
    end else begin
      if (adv1) st1_valid <= in_valid;
      if (adv2) st2_valid <= st1_valid;
    end
  end
endmodule

// File: rtl/phase_va_prod.sv
module phase_va_prod #(
  parameter int RMS_W = 24,
  parameter int VA_W  = 28
) (
  input  logic              use_nom,
  input  logic [RMS_W-1:0]  nom_v,
  input  logic [RMS_W-1:0]  vrms,
  input  logic [RMS_W-1:0]  irms,
  output logic [VA_W-1:0]   prod_q
);
  localparam int PROD_W = 2 * RMS_W;
  localparam int KEEP_W = VA_W - 1;

  logic [RMS_W-1:0]  v_sel;
  logic [PROD_W-1:0] prod;

  assign v_sel  = use_nom ? nom_v : vrms;
  assign prod   = v_sel * irms;
  assign prod_q = {1'b0, prod[PROD_W-1 -: KEEP_W]};
endmodule

// File: rtl/phase_va_gain.sv
module phase_va_gain #(
  parameter int VA_W   = 28,
  parameter int GAIN_W = 24
) (
  input  logic [VA_W-1:0]   p,
  input  logic [GAIN_W-1:0] g,
  output logic [VA_W-1:0]   va
);
  localparam int MUL_W = 2 * VA_W;
  localparam int SUM_W = MUL_W + 1;
  localparam int FRAC  = GAIN_W - 1;
  localparam logic signed [SUM_W-1:0] VA_MAX =
    {{(SUM_W-VA_W+1){1'b0}}, {(VA_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] VA_MIN =
    {{(SUM_W-VA_W+1){1'b1}}, {(VA_W-1){1'b0}}};

  logic signed [VA_W-1:0]  p_s, g_s;
  logic signed [MUL_W-1:0] mul, scaled;
  logic signed [SUM_W-1:0] sum;

  assign p_s    = p;
  assign g_s    = {{(VA_W-GAIN_W){g[GAIN_W-1]}}, g};
  assign mul    = p_s * g_s;
  assign scaled = mul >>> FRAC;
  assign sum    = {scaled[MUL_W-1], scaled} + {{(SUM_W-VA_W){p[VA_W-1]}}, p};

  always_comb begin
    if (sum > VA_MAX)      va = VA_MAX[VA_W-1:0];
    else if (sum < VA_MIN) va = VA_MIN[VA_W-1:0];
    else                   va = sum[VA_W-1:0];
  end
endmodule

// File: rtl/phase_va_calc.sv
module phase_va_calc
  import phase_va_pkg::*;
#(
  parameter int NUM_PH   = NUM_PH_D,
  parameter int RMS_W    = RMS_W_D,
  parameter int VA_W     = VA_W_D,
  parameter int GAIN_W   = GAIN_W_D,
  parameter int CFG_AW   = CFG_AW_D,
  parameter int CFG_DW   = CFG_DW_D,
  parameter int MODE_LSB = MODE_LSB_D
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NUM_PH*RMS_W-1:0] in_vrms,
  input  logic [NUM_PH*RMS_W-1:0] in_irms,
  input  logic                    cfg_we,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [CFG_DW-1:0]       cfg_wdata,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NUM_PH*VA_W-1:0]  out_va
);
  logic [RMS_W-1:0]         nom_v;
  logic [NUM_PH-1:0]        nom_sel;
  logic [NUM_PH*GAIN_W-1:0] gain_flat;
  logic                     st1_valid, ld1, ld2;

  phase_va_cfg #(
    .NUM_PH(NUM_PH), .RMS_W(RMS_W), .GAIN_W(GAIN_W),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .MODE_LSB(MODE_LSB)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .nom_v(nom_v), .nom_sel(nom_sel), .gain_flat(gain_flat)
  );

  phase_va_pipe_ctl ctl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_ready(out_ready), .st1_valid(st1_valid), .st2_valid(out_valid),
    .ld1(ld1), .ld2(ld2)
  );

  for (genvar ph = 0; ph < NUM_PH; ph++) begin : g_lane
    logic [VA_W-1:0]   prod_d, prod_r, va_d;
    logic [GAIN_W-1:0] gain_r;

    phase_va_prod #(.RMS_W(RMS_W), .VA_W(VA_W)) prod_i (
      .use_nom(nom_sel[ph]), .nom_v(nom_v),
      .vrms(in_vrms[ph*RMS_W +: RMS_W]), .irms(in_irms[ph*RMS_W +: RMS_W]),
      .prod_q(prod_d)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prod_r <= '0;
        gain_r <= '0;
      end else if (ld1) begin
        prod_r <= prod_d;
        gain_r <= gain_flat[ph*GAIN_W +: GAIN_W];
      end
    end

    phase_va_gain #(.VA_W(VA_W), .GAIN_W(GAIN_W)) gain_i (
      .p(prod_r), .g(gain_r), .va(va_d)
    );

    always_ff @(posedge clk) begin
      if (!rst_n)   out_va[ph*VA_W +: VA_W] <= '0;
      else if (ld2) out_va[ph*VA_W +: VA_W] <= va_d;
    end
  end
endmodule

// File: rtl/phase_va_calc_chk.sv
module phase_va_calc_chk #(
  parameter int NUM_PH = 3,
  parameter int VA_W   = 28
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic                   st1_valid,
  input logic [NUM_PH*VA_W-1:0] out_va
);
  logic neg_any;
  always_comb begin
    neg_any = 1'b0;
    for (int ph = 0; ph < NUM_PH; ph++)
      if (out_va[ph*VA_W + VA_W - 1]) neg_any = 1'b1;
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);                          // R8
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_va));                    // R8
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    st1_valid && out_valid && !out_ready |-> !in_ready);             // R8
  AST_ACCEPT_ST1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> st1_valid);                             // R7
  AST_ST1_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    st1_valid && (!out_valid || out_ready) |=> out_valid);           // R7
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !st1_valid |-> in_ready);                                        // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !neg_any);                                         // R5
endmodule

bind phase_va_calc phase_va_calc_chk #(.NUM_PH(NUM_PH), .VA_W(VA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .st1_valid(st1_valid),
  .out_va(out_va)
);

// File: tb/phase_va_calc_tb_top.sv
module phase_va_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [71:0] in_vrms = '0;
  logic [71:0] in_irms = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [83:0] out_va;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [2:0]  mode_m = '0;
  logic [23:0] nom_m  = '0;
  logic [23:0] gain_m [3] = '{default: '0};
  logic [27:0] last_va [3];

  always #10 clk = ~clk;

  phase_va_calc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vrms(in_vrms), .in_irms(in_irms), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_va(out_va)
  );

  function automatic logic [27:0] model(input logic [23:0] v, input logic [23:0] i,
                                        input logic [23:0] g24);
    longint p, g, q;
    p = (longint'(v) * longint'(i)) >>> 21;
    g = longint'(g24);
    if (g >= 64'sd8388608) g = g - 64'sd16777216;
    q = p + ((p * g) >>> 23);
    if (q > 64'sd134217727) q = 64'sd134217727;
    if (q < -64'sd134217728) q = -64'sd134217728;
    return q[27:0];
  endfunction

  function automatic logic [27:0] expect_ph(input int ph, input logic [71:0] vr,
                                            input logic [71:0] ir);
    logic [23:0] v;
    v = mode_m[ph] ? nom_m : vr[ph*24 +: 24];
    return model(v, ir[ph*24 +: 24], gain_m[ph]);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      3'd0: nom_m = d[23:0];
      3'd1: mode_m = d[13:11];
      3'd2: gain_m[0] = d[23:0];
      3'd3: gain_m[1] = d[23:0];
      3'd4: gain_m[2] = d[23:0];
      default: ;
    endcase
  endtask

  task automatic send_chk(input string req, input logic [71:0] vr, input logic [71:0] ir);
    logic [27:0] e [3];
    for (int ph = 0; ph < 3; ph++) e[ph] = expect_ph(ph, vr, ir);
    @(negedge clk);
    in_valid = 1'b1; in_vrms = vr; in_irms = ir;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 cycle n+1 idle", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R7 cycle n+2 valid", 64'(out_valid), 64'd1);
    for (int ph = 0; ph < 3; ph++) begin
      last_va[ph] = out_va[ph*28 +: 28];
      chk(req, 64'(last_va[ph]), 64'(e[ph]));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_measured;
    send_chk("R2 mid", {3{24'h800000}}, {3{24'h800000}});
    chk("R2 literal", 64'(last_va[0]), 64'h2000000);
    send_chk("R2 full", {3{24'hFFFFFF}}, {3{24'hFFFFFF}});
    send_chk("R2 mixed", {24'h000000, 24'h123456, 24'hABCDEF},
                         {24'h7FFFFF, 24'h00ABCD, 24'h000001});
  endtask

  task automatic t_nominal;
    cfg_write(3'd0, 32'h00600000);
    cfg_write(3'd1, 32'h00001000);
    send_chk("R3 phase B only", {24'h100000, 24'h200000, 24'h300000}, {3{24'h400000}});
    chk("R3 phase B nominal", 64'(last_va[1]), 64'(model(24'h600000, 24'h400000, 24'h0)));
    chk("R3 phase A measured", 64'(last_va[0]), 64'(model(24'h300000, 24'h400000, 24'h0)));
    cfg_write(3'd1, 32'h00003800);
    send_chk("R3 all nominal", {24'h111111, 24'h222222, 24'h333333},
                               {24'hFFFFFF, 24'h123456, 24'h0F0F0F});
    cfg_write(3'd1, 32'h0);
  endtask

  task automatic t_gain;
    cfg_write(3'd2, 32'h00C00000);
    cfg_write(3'd3, 32'h00400000);
    cfg_write(3'd4, 32'h00F00001);
    send_chk("R4 gains", {3{24'h800000}}, {3{24'h800000}});
    chk("R4 minus half", 64'(last_va[0]), 64'h1000000);
    chk("R4 plus half", 64'(last_va[1]), 64'h3000000);
    send_chk("R4 odd values", {24'h123457, 24'hFEDCBA, 24'h00FFFF},
                              {24'h0ABCDE, 24'h765432, 24'hFFFF00});
  endtask

  task automatic t_sat;
    cfg_write(3'd2, 32'h007FFFFF);
    cfg_write(3'd3, 32'h007FFFFF);
    cfg_write(3'd4, 32'h00000000);
    send_chk("R5 clamp", {3{24'hFFFFFF}}, {3{24'hFFFFFF}});
    chk("R5 clamp A", 64'(last_va[0]), 64'h7FFFFFF);
    chk("R5 clamp B", 64'(last_va[1]), 64'h7FFFFFF);
  endtask

  task automatic t_upper;
    cfg_write(3'd2, 32'hAB400000);
    cfg_write(3'd3, 32'h00000000);
    cfg_write(3'd0, 32'hFF000100);
    cfg_write(3'd1, 32'hFFFFC7FF);
    cfg_write(3'd5, 32'h00C00000);
    cfg_write(3'd6, 32'hFFFFFFFF);
    cfg_write(3'd7, 32'h00400000);
    send_chk("R6 ignored bits", {3{24'h800000}}, {3{24'h800000}});
    chk("R6 gain upper bits", 64'(last_va[0]), 64'h3000000);
    chk("R6 mode other bits", 64'(last_va[1]), 64'h2000000);
  endtask

  task automatic t_cfg_timing;
    logic [71:0] vr, ir;
    logic [27:0] e [3];
    cfg_write(3'd2, 32'h0);
    vr = {3{24'h800000}};
    ir = {3{24'h800000}};
    for (int ph = 0; ph < 3; ph++) e[ph] = expect_ph(ph, vr, ir);
    @(negedge clk);
    in_valid = 1'b1; in_vrms = vr; in_irms = ir;
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 32'h00C00000;
    @(negedge clk);
    in_valid = 1'b0;
    cfg_addr = 3'd3; cfg_wdata = 32'h00400000;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int ph = 0; ph < 3; ph++)
      chk("R9 in-flight keeps old config", 64'(out_va[ph*28 +: 28]), 64'(e[ph]));
    gain_m[0] = 24'hC00000;
    gain_m[1] = 24'h400000;
    send_chk("R9 next beat uses new config", vr, ir);
    chk("R9 new gain A", 64'(last_va[0]), 64'h1000000);
  endtask

  task automatic t_backpressure;
    logic [71:0] va, vb, vc, ir;
    logic [27:0] ea [3], eb [3], ec [3];
    va = {3{24'h100000}}; vb = {3{24'h200000}}; vc = {3{24'h300000}};
    ir = {3{24'hFFFFFF}};
    for (int ph = 0; ph < 3; ph++) begin
      ea[ph] = expect_ph(ph, va, ir);
      eb[ph] = expect_ph(ph, vb, ir);
      ec[ph] = expect_ph(ph, vc, ir);
    end
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_vrms = va; in_irms = ir;
    @(negedge clk);
    in_vrms = vb;
    @(negedge clk);
    in_vrms = vc;
    chk("R8 in_ready low when full", 64'(in_ready), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 held valid", 64'(out_valid), 64'd1);
      chk("R8 held data", 64'(out_va[27:0]), 64'(ea[0]));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int ph = 0; ph < 3; ph++)
      chk("R8 order second", 64'(out_va[ph*28 +: 28]), 64'(eb[ph]));
    @(negedge clk);
    for (int ph = 0; ph < 3; ph++)
      chk("R8 order third", 64'(out_va[ph*28 +: 28]), 64'(ec[ph]));
    @(negedge clk);
    chk("R8 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 during reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    t_reset();
    t_measured();
    t_nominal();
    t_gain();
    t_sat();
    t_upper();
    t_cfg_timing();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule